// File: doc/BRIEF.md
# Clock-Enable-Parked Single Byte SDRAM Writer

This block lets a slow host that runs on its own clock place one byte at one column of an open SDR SDRAM row. The host does not need to meet any cycle-exact timing. It first requests a column and a byte lane. The block then starts a full-page WRITE burst one column before the target. Every lane is masked on that command, so the column written by the WRITE itself is thrown away.

On the next cycle the block lowers clock enable. The burst therefore rests with its column pointer on the target. It can stay there for as long as the host takes. When the host signals that its data is ready, the block does the following in order:

1. Drives the byte onto the target lane.
2. Unmasks only that lane.
3. Raises clock enable for a single SDRAM clock, which writes the target column.
4. Masks all lanes again.
5. Closes the burst with a burst terminate and then a precharge.
6. Reports completion.

A parameter selects a second, cycle-counted variant. In that variant clock enable stays high, the burst starts a fixed number of columns early, and the lane is unmasked exactly that many cycles after the WRITE.

Top module: `sdram_lane_poke`

## Requirements
- R1: A request issues one WRITE command (CS#,RAS#,CAS#,WE# = 0,1,0,0) with CKE high and all DQM bits high. In parked mode the WRITE address is the target column minus one.
- R2: Start columns wrap modulo the page size of 1024 columns. In parked mode, target column 0 starts the burst at column 1023, and target column 1023 starts it at 1022.
- R3: In parked mode, CKE is low in the cycle after the WRITE. It stays low, with every DQM bit high, for as long as the host withholds its data-ready strobe.
- R4: After the data-ready strobe, the byte is driven on the DQ bus one cycle before CKE rises, with only the target lane's DQM bit low. CKE is then high for exactly one cycle. Only the target byte of the target column changes in memory.
- R5: At no time is more than one DQM bit low, and the DQ bus is driven whenever a DQM bit is low.
- R6: Each host strobe passes through a two-flop synchronizer and a rising-edge detector. One request yields exactly one burst advance in parked mode, however long the strobe is held.
- R7: After the byte is written, CKE is low again with all DQM bits high. Then BURST TERMINATE (0,1,1,0) and PRECHARGE (0,0,1,0 with address bit 10 high) are issued. Only then does done rise. Done stays high until the next request.
- R8: In cycle-counted mode (PAUSE_MODE=0), the WRITE addresses the target column minus LEAD, with a default LEAD of 11. CKE stays high throughout. The target lane is unmasked on exactly the LEAD-th clock after the WRITE, and the byte is taken with the request.
- R9: A data-ready strobe while no request is parked issues no command and changes no memory.
- R10: After reset the command is NOP (0,1,1,1), CKE is high, all DQM bits are high, done is low and the DQ bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Active-low reset |
| host_go | input | 1 | Asynchronous request strobe; the column and lane are valid while it is high |
| host_fire | input | 1 | Asynchronous data-ready strobe (parked mode) |
| host_col | input | COL_W | Target column |
| host_lane | input | LANE_W | Target byte lane |
| host_data | input | 8 | Byte to write |
| host_done | output | 1 | Operation finished; cleared by the next request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | LANES | Per-lane data mask, high masks |
| sd_addr | output | ADDR_W | Address bus |
| sd_dq | output | 8*LANES | Write data, the byte replicated on every lane |
| sd_dq_oe | output | 1 | DQ drive enable |

## Verification
Parked writes are tried at column 0 and at column 1023, where the start column wraps in both directions, and at a mid-page column. Between these runs the lane, the data and the time spent parked all vary. A long-held data-ready strobe separates a true edge-triggered one-shot from a level-sensitive enable, because the level-sensitive version lets the burst advance more than once. A stray data-ready strobe while idle shows whether the idle state ignores it. A second instance in cycle-counted mode is checked for its start column and its advance count, which shows whether the unmask lands on the LEAD-th clock.

// File: rtl/sdram_lane_poke.sv
`timescale 1ns/1ps
module sdram_lane_poke #(
  parameter int COLS       = 1024,
  parameter int LANES      = 8,
  parameter int ADDR_W     = 13,
  parameter bit PAUSE_MODE = 1'b1,
  parameter int LEAD       = 11,
  localparam int COL_W  = $clog2(COLS),
  localparam int LANE_W = $clog2(LANES),
  localparam int DQ_W   = 8 * LANES,
  localparam int CNT_W  = $clog2(LEAD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_go,
  input  logic              host_fire,
  input  logic [COL_W-1:0]  host_col,
  input  logic [LANE_W-1:0] host_lane,
  input  logic [7:0]        host_data,
  output logic              host_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [LANES-1:0]  sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQ_W-1:0]   sd_dq,
  output logic              sd_dq_oe
);
  localparam int OFF = PAUSE_MODE ? 1 : LEAD;
  localparam logic [3:0] C_NOP = 4'b0111, C_WR = 4'b0100,
                         C_BST = 4'b0110, C_PRE = 4'b0010;

  typedef enum logic [3:0] {S_IDLE, S_WR, S_PARK, S_ARM, S_SHOT,
                            S_HOLD, S_CNT, S_TERM, S_PRE} st_t;
  st_t state, nxt;

  logic [2:0]        go_s, fire_s;
  logic [COL_W-1:0]  start_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [3:0]        cmd;

  wire go_rise   = go_s[1] & ~go_s[2];
  wire fire_rise = fire_s[1] & ~fire_s[2];
  wire lane_open = (state == S_SHOT) || (state == S_ARM);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (go_rise) nxt = S_WR;
      S_WR:   nxt = PAUSE_MODE ? S_PARK : ((LEAD > 1) ? S_CNT : S_SHOT);
      S_PARK: if (fire_rise) nxt = S_ARM;
      S_ARM:  nxt = S_SHOT;
      S_SHOT: nxt = PAUSE_MODE ? S_HOLD : S_TERM;
      S_HOLD: nxt = S_TERM;
      S_CNT:  if (cnt_q == '0) nxt = S_SHOT;
      S_TERM: nxt = S_PRE;
      S_PRE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      go_s    <= '0;
      fire_s  <= '0;
      start_q <= '0;
      lane_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      go_s   <= {go_s[1:0], host_go};
      fire_s <= {fire_s[1:0], host_fire};
      state  <= nxt;
      if (state == S_IDLE && go_rise) begin
        start_q <= host_col - COL_W'(OFF);
        lane_q  <= host_lane;
        done_q  <= 1'b0;
        if (!PAUSE_MODE) data_q <= host_data;
      end
      if (state == S_PARK && fire_rise) data_q <= host_data;
      if (state == S_WR) cnt_q <= CNT_W'((LEAD >= 2) ? LEAD - 2 : 0);
      else if (state == S_CNT) cnt_q <= cnt_q - 1'b1;
      if (state == S_PRE) done_q <= 1'b1;
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_addr = '0;
    if (state == S_WR) begin
      cmd     = C_WR;
      sd_addr = ADDR_W'(start_q);
    end else if (state == S_TERM) begin
      cmd = C_BST;
    end else if (state == S_PRE) begin
      cmd         = C_PRE;
      sd_addr[10] = 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke    = !(state == S_PARK || state == S_ARM || state == S_HOLD);
  assign sd_dqm    = lane_open ? ~(LANES'(1) << lane_q) : '1;
  assign sd_dq     = {LANES{data_q}};
  assign sd_dq_oe  = lane_open || state == S_CNT;
  assign host_done = done_q;

  assert_write_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_WR |-> (&sd_dqm && sd_cke));

  assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sd_dqm) <= 1);

  assert_lane_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sd_dqm) |-> sd_dq_oe);

  assert_done_after_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_done) |-> $past(cmd) == C_PRE);

  assert_pre_a10_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_PRE |-> sd_addr[10]);

  generate
    if (PAUSE_MODE) begin : g_park_chk
      assert_park_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_WR |=> (!sd_cke && &sd_dqm));
      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !(&sd_dqm)) |=> (!sd_cke && &sd_dqm));
      assert_data_before_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !(&sd_dqm)) |-> ($past(!sd_cke) && $stable(sd_dq) && $stable(sd_dqm)));
    end else begin : g_count_chk
      assert_cke_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke);
    end
  endgenerate
endmodule

// File: tb/sdram_lane_poke_test.sv
`timescale 1ns/1ps
module col_model #(parameter int COLS = 1024, parameter int LANES = 8) (
  input logic clk,
  input logic cs_n, ras_n, cas_n, we_n, cke, oe,
  input logic [LANES-1:0] dqm,
  input logic [12:0] addr,
  input logic [8*LANES-1:0] dq
);
  logic [8*LANES-1:0] mem [COLS];
  logic [3:0] q_cmd = 4'b0111;
  logic q_cke = 1'b0, q_oe = 1'b0;
  logic [LANES-1:0] q_dqm = '1;
  logic [12:0] q_addr = '0;
  logic [8*LANES-1:0] q_dq = '0;
  int ptr = 0, active = 0, adv = 0, wr_cmds = 0, last_wr = -1;
  int n_bst = 0, n_pre = 0, pre_a10 = 0;

  initial for (int c = 0; c < COLS; c++) mem[c] = {LANES{c[7:0] ^ 8'h5A}};

  always @(negedge clk) begin
    q_cmd = {cs_n, ras_n, cas_n, we_n};
    q_cke = cke; q_oe = oe; q_dqm = dqm; q_addr = addr; q_dq = dq;
  end

  task automatic store();
    for (int l = 0; l < LANES; l++)
      if (!q_dqm[l]) mem[ptr][l*8 +: 8] = q_oe ? q_dq[l*8 +: 8] : 8'hxx;
  endtask

  always @(posedge clk) if (q_cke) begin
    if (q_cmd == 4'b0100) begin
      active = 1; ptr = int'(q_addr) % COLS; wr_cmds++; last_wr = ptr; store();
    end else if (q_cmd == 4'b0110) begin
      active = 0; n_bst++;
    end else if (q_cmd == 4'b0010) begin
      active = 0; n_pre++; if (q_addr[10]) pre_a10++;
    end else if (active != 0) begin
      ptr = (ptr + 1) % COLS; adv++; store();
    end
  end
endmodule

module sdram_lane_poke_test;
  localparam int COLS = 1024, LANES = 8;
  logic clk = 0, rst_n = 0;
  logic go0 = 0, go1 = 0, fire = 0;
  logic [9:0] col = '0;
  logic [2:0] lane = '0;
  logic [7:0] data = '0;
  always #2 clk = ~clk;

  logic done0, cs0, ras0, cas0, we0, cke0, oe0;
  logic [7:0] dqm0; logic [12:0] addr0; logic [63:0] dq0;
  logic done1, cs1, ras1, cas1, we1, cke1, oe1;
  logic [7:0] dqm1; logic [12:0] addr1; logic [63:0] dq1;

  sdram_lane_poke uut (.clk, .rst_n, .host_go(go0), .host_fire(fire), .host_col(col),
    .host_lane(lane), .host_data(data), .host_done(done0), .sd_cs_n(cs0), .sd_ras_n(ras0),
    .sd_cas_n(cas0), .sd_we_n(we0), .sd_cke(cke0), .sd_dqm(dqm0), .sd_addr(addr0),
    .sd_dq(dq0), .sd_dq_oe(oe0));
  sdram_lane_poke #(.PAUSE_MODE(1'b0)) uut_cnt (.clk, .rst_n, .host_go(go1), .host_fire(1'b0),
    .host_col(col), .host_lane(lane), .host_data(data), .host_done(done1), .sd_cs_n(cs1),
    .sd_ras_n(ras1), .sd_cas_n(cas1), .sd_we_n(we1), .sd_cke(cke1), .sd_dqm(dqm1),
    .sd_addr(addr1), .sd_dq(dq1), .sd_dq_oe(oe1));

  col_model m0 (.clk, .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .cke(cke0),
    .oe(oe0), .dqm(dqm0), .addr(addr0), .dq(dq0));
  col_model m1 (.clk, .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .cke(cke1),
    .oe(oe1), .dqm(dqm1), .addr(addr1), .dq(dq1));

  logic [63:0] exp0 [COLS];
  logic [63:0] exp1 [COLS];
  int checks = 0, fails = 0, lane_viol = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int mism(input bit which);
    int n = 0;
    for (int c = 0; c < COLS; c++)
      if ((which ? m1.mem[c] : m0.mem[c]) !== (which ? exp1[c] : exp0[c])) n++;
    return n;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if ($countones(~dqm0) > 1 || $countones(~dqm1) > 1) lane_viol++;
    if ((!(&dqm0) && !oe0) || (!(&dqm1) && !oe1)) lane_viol++;
  end

  task automatic wait_done(input bit which, input string req);
    int t = 0;
    while (!(which ? done1 : done0) && t < 500) begin @(negedge clk); t++; end
    check(t < 500, {req, " watchdog"}, t, 0);
  endtask

  task automatic pulse_go(input bit which, input int c, input int l, input int d);
    @(negedge clk);
    col = 10'(c); lane = 3'(l); data = 8'(d);
    if (which) go1 = 1; else go0 = 1;
    repeat (3) @(negedge clk);
    go0 = 0; go1 = 0;
  endtask

  task automatic park_op(input int c, input int l, input int d, input int park, input int hold);
    int adv0, b0, p0, a0;
    adv0 = m0.adv; b0 = m0.n_bst; p0 = m0.n_pre; a0 = m0.pre_a10;
    pulse_go(0, c, l, 8'h00);
    repeat (park) @(negedge clk);
    check(cke0 == 0 && dqm0 == 8'hFF, "R3 parked cke/dqm", {cke0, dqm0}, 9'h0FF);
    check(m0.last_wr == ((c - 1 + COLS) % COLS), "R1 R2 start column", m0.last_wr,
          (c - 1 + COLS) % COLS);
    data = 8'(d); @(negedge clk);
    fire = 1; repeat (hold) @(negedge clk); fire = 0;
    wait_done(0, "R7");
    exp0[c][l*8 +: 8] = 8'(d);
    check(mism(0) == 0, "R4 only target byte changed", mism(0), 0);
    check(m0.adv - adv0 == 1, "R6 single advance", m0.adv - adv0, 1);
    check(m0.n_bst - b0 == 1 && m0.n_pre - p0 == 1 && m0.pre_a10 - a0 == 1,
          "R7 terminate then precharge", m0.n_pre - p0, 1);
    check(done0 == 1 && cke0 == 1 && dqm0 == 8'hFF, "R7 done level", done0, 1);
  endtask

  task automatic count_op(input int c, input int l, input int d);
    int adv0;
    adv0 = m1.adv;
    pulse_go(1, c, l, d);
    wait_done(1, "R8");
    exp1[c][l*8 +: 8] = 8'(d);
    check(m1.last_wr == ((c - 11 + COLS) % COLS), "R8 start column", m1.last_wr,
          (c - 11 + COLS) % COLS);
    check(m1.adv - adv0 == 11, "R8 advance count", m1.adv - adv0, 11);
    check(mism(1) == 0, "R8 target byte written", mism(1), 0);
  endtask

  initial begin
    int w0;
    for (int c = 0; c < COLS; c++) begin
      exp0[c] = {LANES{c[7:0] ^ 8'h5A}};
      exp1[c] = {LANES{c[7:0] ^ 8'h5A}};
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({cs0, ras0, cas0, we0} == 4'b0111 && cke0 && dqm0 == 8'hFF && !done0 && !oe0,
          "R10 reset outputs", {cs0, ras0, cas0, we0, cke0, dqm0}, {4'b0111, 1'b1, 8'hFF});
    park_op(0, 3, 8'hFF, 10, 2);
    park_op(517, 0, 8'h3C, 200, 30);
    park_op(1023, 7, 8'h81, 12, 1);
    w0 = m0.wr_cmds;
    data = 8'hEE; fire = 1; repeat (4) @(negedge clk); fire = 0;
    repeat (10) @(negedge clk);
    check(m0.wr_cmds == w0 && mism(0) == 0 && cke0 == 1, "R9 idle strobe ignored",
          m0.wr_cmds, w0);
    count_op(5, 4, 8'hC3);
    count_op(600, 1, 8'h11);
    check(lane_viol == 0, "R5 per-cycle lane mask", lane_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule